// File: doc/BRIEF.md
# Cascadable Circular Sampling Ring

This block is a digital model of a ring of sample storage cells. While sampling, a shared write pointer advances one cell per clock, and every channel stores the sample presented on its input lane at that pointer. Before a cell is overwritten, the cell ahead of it is zeroed. The physical rings can be chained so that fewer logical channels each get a deeper ring. A stop request freezes writing and latches the cell index written on that edge. The frozen contents are then read out oldest first, starting one cell past the stop cell. Readout uses either a single multiplexed lane that walks the channels in turn, or all channels side by side.

A tap output toggles once per revolution of a base ring. A chain interface lets several arrays form one deeper channel. In chain mode an array writes only while it holds a token. It receives the token on its chain input, hands it on through its chain output after its last logical cell, and then waits.

The package constants set the defaults: 8 physical rings of 32 cells each, with 8-bit samples. The production depth of 1024 cells per ring is reached by changing one constant.

Top module: `cascade_sample_ring`

## Requirements
- R1: After reset, rdValid, done, tapOut, chainOut, stopCell and rdData are all zero, the block is sampling, and every cell reads as zero.
- R2: cascadeMode m (0..3) gives 8>>m logical channels of 32<<m cells each, which is depth D. On each write edge, logical channel l stores the lane l sample (sampleIn bits l*8+7..l*8) at logical cell (write count mod D).
- R3: Clear-before-write: on each write edge, the logical cell after the one being written is zeroed. As a result, the first sample read after a stop is always zero.
- R4: A write edge with stopReq high still stores its sample. On that edge stopCell takes the logical cell just written, writing halts, and readPar is latched as the readout mode.
- R5: In the stopped state, each clock with readEn high yields one sample, with rdValid high in the following cycle. Each channel's samples come out starting at cell stopCell+1 and wrapping modulo D, oldest first.
- R6: With latched readPar=0, the strobes walk all D cells of channel 0, then all D cells of channel 1, and so on. The sample appears on lane 0, rdChan gives the channel, and lanes 1..7 are zero.
- R7: With latched readPar=1, each strobe gives the same cell offset of every logical channel, channel l on lane l. Lanes at or above 8>>m are zero.
- R8: done rises together with the last sample (256 strobes multiplexed, D strobes parallel). It stays high until arm, and any further readEn gives no rdValid.
- R9: readEn while sampling has no effect. stopReq and sampleIn while stopped change neither stopCell nor the stored cells.
- R10: tapOut toggles on the write edge that writes base-ring cell 31. It therefore completes one period every 64 writes.
- R11: With chainEn high, writing waits for a chainIn pulse and then runs for exactly D write edges. chainOut pulses for one cycle with the write of logical cell D-1, and writing then pauses until the next chainIn.
- R12: arm while stopped or done returns the block to sampling and clears done. The write pointer continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and read clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 64 | Eight 8-bit input lanes, lane l at bits l*8 upward |
| cascadeMode | input | 2 | Depth/channel trade: 0 = 8x32, 1 = 4x64, 2 = 2x128, 3 = 1x256 |
| stopReq | input | 1 | Freeze sampling after the current write |
| arm | input | 1 | Resume sampling after a stop |
| readEn | input | 1 | Readout strobe, one sample per high clock |
| readPar | input | 1 | Readout mode latched at the stop: 0 multiplexed, 1 parallel |
| chainEn | input | 1 | Write only while the chain token is held |
| chainIn | input | 1 | Token from the previous array |
| rdData | output | 64 | Readout lanes |
| rdValid | output | 1 | rdData holds a new sample |
| rdChan | output | 3 | Channel of the multiplexed sample |
| done | output | 1 | Readout finished |
| stopCell | output | 8 | Logical cell written on the stop edge |
| tapOut | output | 1 | Revolution tap |
| chainOut | output | 1 | Token to the next array |

## Verification
The stop edge is also a write edge, and it carries the clear of the following cell. Stop, store and clear-before-write therefore all land in the same cycle. The bench provokes this in every cascade mode and in both readout modes, including runs that stop after the ring has wrapped several times and runs that stop before one revolution is complete. It judges the outcome at the ports: stopCell must equal the write count modulo D, the first sample read must be zero, and the remaining samples must match the input history, oldest first. The chain handover and a base-ring wrap can likewise coincide, and these are judged by the exact edge on which chainOut and tapOut change.

// File: rtl/sring_pkg.sv
`timescale 1ns/1ps
package sring_pkg;
  // Configuration of the array; production depth is 1024 cells per ring.
  localparam int RING_CELLS = 32;
  localparam int RING_LANES = 8;
  localparam int SAMPLE_W   = 8;
  localparam int TOTAL      = RING_CELLS * RING_LANES;
  localparam int PTR_W      = $clog2(TOTAL);
  localparam int CELL_B     = $clog2(RING_CELLS);
  localparam int CHAN_W     = $clog2(RING_LANES);

  typedef enum logic [1:0] {ST_SAMPLE = 2'd0, ST_HALT = 2'd1, ST_FIN = 2'd2} ringState_t;

  // Strobes from control to storage.
  typedef struct packed {
    logic              wrEn;
    logic [PTR_W-1:0]  wrCell;
    logic [PTR_W-1:0]  clrCell;
    logic [1:0]        wrMode;
    logic              rdEn;
    logic              rdPar;
    logic [1:0]        rdMode;
    logic [PTR_W-1:0]  rdCell;
    logic [CHAN_W-1:0] rdChan;
  } ringStrobe_t;
endpackage

// File: rtl/ring_ctrl.sv
`timescale 1ns/1ps
module ring_ctrl
  import sring_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cascadeMode,
  input  logic             stopReq,
  input  logic             arm,
  input  logic             readEn,
  input  logic             readPar,
  input  logic             chainEn,
  input  logic             chainIn,
  output ringStrobe_t      ctl,
  output logic [PTR_W-1:0] stopCell,
  output logic             tapOut,
  output logic             chainOut,
  output logic             done
);
  ringState_t       state;
  logic [PTR_W-1:0] wp, stopCellR, rdIdx, liveMask, heldMask, lc, lastIdx, kIdx;
  logic [1:0]       heldMode;
  logic             heldPar, tok, active, rdFire, tapR, chainOutR, doneR;

  always_comb begin
    liveMask = PTR_W'((RING_CELLS << cascadeMode) - 1);
    heldMask = PTR_W'((RING_CELLS << heldMode) - 1);
    lc       = wp & liveMask;
    active   = (state == ST_SAMPLE) && (!chainEn || tok);
    rdFire   = (state == ST_HALT) && readEn && !arm;
    lastIdx  = heldPar ? heldMask : {PTR_W{1'b1}};
    kIdx     = heldPar ? rdIdx : (rdIdx & heldMask);
  end

  always_comb begin
    ctl         = '0;
    ctl.wrEn    = active;
    ctl.wrCell  = lc;
    ctl.clrCell = (lc + PTR_W'(1)) & liveMask;
    ctl.wrMode  = cascadeMode;
    ctl.rdEn    = rdFire;
    ctl.rdPar   = heldPar;
    ctl.rdMode  = heldMode;
    ctl.rdCell  = (stopCellR + PTR_W'(1) + kIdx) & heldMask;
    ctl.rdChan  = heldPar ? '0 : CHAN_W'(rdIdx >> (CELL_B + int'(heldMode)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SAMPLE;
      wp        <= '0;
      stopCellR <= '0;
      rdIdx     <= '0;
      heldMode  <= '0;
      heldPar   <= 1'b0;
      tok       <= 1'b0;
      tapR      <= 1'b0;
      chainOutR <= 1'b0;
      doneR     <= 1'b0;
    end else begin
      chainOutR <= 1'b0;
      if (state == ST_SAMPLE && chainEn && !tok && chainIn) tok <= 1'b1;
      if (active) begin
        wp <= wp + PTR_W'(1);
        if (wp[CELL_B-1:0] == {CELL_B{1'b1}}) tapR <= ~tapR;
        if (chainEn && lc == liveMask) begin
          tok       <= 1'b0;
          chainOutR <= 1'b1;
        end
        if (stopReq) begin
          state     <= ST_HALT;
          stopCellR <= lc;
          heldMode  <= cascadeMode;
          heldPar   <= readPar;
          rdIdx     <= '0;
        end
      end
      if ((state == ST_HALT || state == ST_FIN) && arm) begin
        state <= ST_SAMPLE;
        doneR <= 1'b0;
      end else if (rdFire) begin
        rdIdx <= rdIdx + PTR_W'(1);
        if (rdIdx == lastIdx) begin
          state <= ST_FIN;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign stopCell = stopCellR;
  assign tapOut   = tapR;
  assign chainOut = chainOutR;
  assign done     = doneR;

  // R4: the latched stop cell never moves once sampling has stopped
  a_r4_stop_cell_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SAMPLE) |=> $stable(stopCellR));
  // R10: the tap changes only on write edges
  a_r10_tap_idle: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> $stable(tapR));
  // R11: the chain output is a single-cycle pulse
  a_r11_chain_pulse: assert property (@(posedge clk) disable iff (!rstN)
    chainOutR |=> !chainOutR);
  // R9: no read strobe reaches storage while sampling
  a_r9_no_read_sampling: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAMPLE) |-> !ctl.rdEn);
  // R8: a finished readout accepts no further strobes
  a_r8_done_blocks: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> !rdFire);
endmodule

// File: rtl/ring_store.sv
`timescale 1ns/1ps
module ring_store
  import sring_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  ringStrobe_t                    ctl,
  input  logic [RING_LANES*SAMPLE_W-1:0] sampleIn,
  output logic [RING_LANES*SAMPLE_W-1:0] rdData,
  output logic                           rdValid,
  output logic [CHAN_W-1:0]              rdChan
);
  // Logical (channel l, cell c) sits at flat address l*D + c, so chained rings are contiguous.
  logic [SAMPLE_W-1:0] cellMem  [TOTAL];
  logic [SAMPLE_W-1:0] laneNext [RING_LANES];
  logic [SAMPLE_W-1:0] laneQ    [RING_LANES];
  logic                rdValidR, parQ;
  logic [CHAN_W-1:0]   rdChanR;

  function automatic logic [PTR_W-1:0] laneBase(input int lane, input logic [1:0] m);
    return PTR_W'(lane) << (CELL_B + int'(m));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) cellMem[i] <= '0;
    end else if (ctl.wrEn) begin
      for (int l = 0; l < RING_LANES; l++) begin
        if (l < (RING_LANES >> ctl.wrMode)) begin
          cellMem[laneBase(l, ctl.wrMode) | ctl.clrCell] <= '0;
          cellMem[laneBase(l, ctl.wrMode) | ctl.wrCell]  <= sampleIn[l*SAMPLE_W +: SAMPLE_W];
        end
      end
    end
  end

  for (genvar g = 0; g < RING_LANES; g++) begin : g_lane
    if (g == 0) begin : g_mux
      always_comb begin
        if (ctl.rdPar) laneNext[g] = cellMem[laneBase(g, ctl.rdMode) | ctl.rdCell];
        else           laneNext[g] = cellMem[laneBase(int'(ctl.rdChan), ctl.rdMode) | ctl.rdCell];
      end
    end else begin : g_par
      always_comb begin
        if (ctl.rdPar && (g < (RING_LANES >> ctl.rdMode)))
          laneNext[g] = cellMem[laneBase(g, ctl.rdMode) | ctl.rdCell];
        else
          laneNext[g] = '0;
      end
      // R6: multiplexed readout leaves the upper lanes at zero
      a_r6_mux_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
        (rdValidR && !parQ) |-> (laneQ[g] == '0));
    end
    assign rdData[g*SAMPLE_W +: SAMPLE_W] = laneQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < RING_LANES; l++) laneQ[l] <= '0;
      rdValidR <= 1'b0;
      rdChanR  <= '0;
      parQ     <= 1'b0;
    end else begin
      rdValidR <= ctl.rdEn;
      if (ctl.rdEn) begin
        for (int l = 0; l < RING_LANES; l++) laneQ[l] <= laneNext[l];
        rdChanR <= ctl.rdChan;
        parQ    <= ctl.rdPar;
      end
    end
  end

  assign rdValid = rdValidR;
  assign rdChan  = rdChanR;

  // R5: one valid sample in the cycle after each strobe, none otherwise
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdEn |=> rdValidR);
  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> !rdValidR);
endmodule

// File: rtl/cascade_sample_ring.sv
`timescale 1ns/1ps
module cascade_sample_ring
  import sring_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [RING_LANES*SAMPLE_W-1:0] sampleIn,
  input  logic [1:0]                     cascadeMode,
  input  logic                           stopReq,
  input  logic                           arm,
  input  logic                           readEn,
  input  logic                           readPar,
  input  logic                           chainEn,
  input  logic                           chainIn,
  output logic [RING_LANES*SAMPLE_W-1:0] rdData,
  output logic                           rdValid,
  output logic [CHAN_W-1:0]              rdChan,
  output logic                           done,
  output logic [PTR_W-1:0]               stopCell,
  output logic                           tapOut,
  output logic                           chainOut
);
  ringStrobe_t ctl;

  ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cascadeMode(cascadeMode), .stopReq(stopReq), .arm(arm),
    .readEn(readEn), .readPar(readPar), .chainEn(chainEn), .chainIn(chainIn),
    .ctl(ctl), .stopCell(stopCell), .tapOut(tapOut), .chainOut(chainOut), .done(done)
  );

  ring_store u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .rdData(rdData), .rdValid(rdValid), .rdChan(rdChan)
  );
endmodule

// File: tb/sim_cascade_sample_ring.sv
`timescale 1ns/1ps
module sim_cascade_sample_ring;
  import sring_pkg::*;
  localparam int W = SAMPLE_W;
  localparam int L = RING_LANES;
  localparam int C = RING_CELLS;
  localparam int TOT = L * C;
  // mode, parallel, writes (last write carries the stop)
  localparam int VEC [6][3] = '{'{0, 0, 40}, '{1, 1, 100}, '{2, 0, 200},
                                '{3, 1, 300}, '{0, 1, 10},  '{3, 0, 20}};

  logic clk = 1'b0, rstN = 1'b0;
  logic [L*W-1:0] sampleIn = '0;
  logic [1:0] cascadeMode = '0;
  logic stopReq = 0, arm = 0, readEn = 0, readPar = 0, chainEn = 0, chainIn = 0;
  logic [L*W-1:0] rdData;
  logic rdValid, done, tapOut, chainOut;
  logic [CHAN_W-1:0] rdChan;
  logic [PTR_W-1:0] stopCell;
  int checks = 0, fails = 0, nWr = 0;

  always #4 clk = ~clk;

  cascade_sample_ring u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .cascadeMode(cascadeMode),
    .stopReq(stopReq), .arm(arm), .readEn(readEn), .readPar(readPar),
    .chainEn(chainEn), .chainIn(chainIn), .rdData(rdData), .rdValid(rdValid),
    .rdChan(rdChan), .done(done), .stopCell(stopCell), .tapOut(tapOut), .chainOut(chainOut)
  );

  function automatic logic [W-1:0] dataFn(input int n, input int l);
    return W'(n * 7 + l * 31 + 3);
  endfunction

  function automatic int expVal(input int nStop, input int d, input int l, input int k);
    int n;
    if (k == 0) return 0;
    n = nStop - (d - 1) + k;
    if (n < 0) return 0;
    return int'(dataFn(n, l));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic lane(input int l, output int v);
    v = int'(rdData[l*W +: W]);
  endtask

  task automatic writeEdge(input bit stop);
    for (int l = 0; l < L; l++) sampleIn[l*W +: W] = dataFn(nWr, l);
    stopReq = stop;
    @(posedge clk); @(negedge clk);
    stopReq = 0;
    nWr++;
  endtask

  task automatic idleEdge();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic resetDut();
    rstN = 0; stopReq = 0; arm = 0; readEn = 0; chainEn = 0; chainIn = 0;
    repeat (2) @(negedge clk);
    rstN = 1; nWr = 0;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mode, par, nw, d, nl, nStop, total, v0, tapHold;
    @(negedge clk);

    // R1 reset state
    resetDut();
    chk("R1", "rdValid", int'(rdValid), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "tapOut", int'(tapOut), 0);
    chk("R1", "chainOut", int'(chainOut), 0);
    chk("R1", "stopCell", int'(stopCell), 0);
    chk("R1", "rdData", (rdData == '0) ? 0 : 1, 0);

    // Table of modes and stop points
    for (int v = 0; v < 6; v++) begin
      mode = VEC[v][0]; par = VEC[v][1]; nw = VEC[v][2];
      d = C << mode; nl = L >> mode;
      resetDut();
      cascadeMode = 2'(mode); readPar = par[0];
      for (int i = 0; i < nw; i++) writeEdge(i == nw - 1);
      nStop = nw - 1;
      chk("R4", "stopCell", int'(stopCell), nStop & (d - 1));
      total = par ? d : TOT;
      readEn = 1;
      for (int r = 0; r < total; r++) begin
        idleEdge();
        chk("R5", "rdValid", int'(rdValid), 1);
        if (par) begin
          for (int l = 0; l < L; l++) begin
            lane(l, v0);
            chk(l < nl ? ((r == 0) ? "R3" : "R7") : "R7", "parallel lane", v0,
                l < nl ? expVal(nStop, d, l, r) : 0);
          end
        end else begin
          chk("R6", "rdChan", int'(rdChan), r / d);
          lane(0, v0);
          chk((r % d == 0) ? "R3" : "R2", "mux sample", v0, expVal(nStop, d, r / d, r % d));
          chk("R6", "upper lanes", (rdData[L*W-1:W] == '0) ? 0 : 1, 0);
        end
        if (r == total - 2) chk("R8", "done early", int'(done), 0);
        if (r == total - 1) chk("R8", "done at last", int'(done), 1);
      end
      idleEdge();
      chk("R8", "strobe after done", int'(rdValid), 0);
      chk("R8", "done held", int'(done), 1);
      readEn = 0;

      if (v == 0) begin
        // R12 re-arm and pointer continuation
        arm = 1; idleEdge(); arm = 0;
        chk("R12", "done cleared", int'(done), 0);
        for (int i = 0; i < 5; i++) writeEdge(i == 4);
        chk("R12", "stopCell continues", int'(stopCell), 44 & (C - 1));
        readEn = 1;
        idleEdge(); lane(0, v0);
        chk("R3", "first after rearm", v0, 0);
        idleEdge(); lane(0, v0);
        chk("R12", "second after rearm", v0, int'(dataFn(14, 0)));
        readEn = 0;
      end
    end

    // R9 strobes while sampling and stop/data while stopped
    resetDut();
    cascadeMode = 0; readPar = 0; readEn = 1;
    for (int i = 0; i < 3; i++) begin
      writeEdge(0);
      chk("R9", "read while sampling", int'(rdValid), 0);
    end
    readEn = 0;
    for (int i = 3; i < 50; i++) writeEdge(i == 49);
    chk("R4", "stopCell", int'(stopCell), 49 & (C - 1));
    sampleIn = '1;
    stopReq = 1;
    repeat (3) idleEdge();
    stopReq = 0;
    chk("R9", "stopCell unchanged", int'(stopCell), 17);
    readEn = 1;
    idleEdge(); lane(0, v0);
    chk("R3", "first sample zero", v0, 0);
    idleEdge(); lane(0, v0);
    chk("R9", "stored data untouched", v0, int'(dataFn(19, 0)));
    readEn = 0;

    // R10 revolution tap
    resetDut();
    cascadeMode = 0;
    for (int i = 0; i < 70; i++) begin
      writeEdge(0);
      if (i == 30 || i == 31 || i == 62 || i == 63)
        chk("R10", "tapOut", int'(tapOut), ((i + 1) / C) & 1);
    end
    chk("R11", "no chainOut unchained", int'(chainOut), 0);

    // R11 chain token handling, full depth
    resetDut();
    chainEn = 1; cascadeMode = 3;
    repeat (5) idleEdge();
    chk("R11", "idle without token", int'(tapOut), 0);
    chainIn = 1; idleEdge(); chainIn = 0;
    for (int e = 1; e <= 257; e++) begin
      idleEdge();
      if (e == 255) chk("R11", "chainOut before last", int'(chainOut), 0);
      if (e == 256) chk("R11", "chainOut at last cell", int'(chainOut), 1);
      if (e == 257) chk("R11", "chainOut pulse width", int'(chainOut), 0);
    end
    tapHold = int'(tapOut);
    repeat (40) idleEdge();
    chk("R11", "halted after handoff", int'(tapOut), tapHold);
    chk("R11", "no second pulse", int'(chainOut), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule